// File: doc/BRIEF.md
# SPI Flash Single-Cycle Command Engine

The block is a register-programmed master for serial flash parts on a single-lane SPI link in mode 0, with the clock idling low. Software loads an eight-entry opcode menu, a two-bit cycle type for each entry, an optional one-byte prefix opcode, a flash address and up to 64 data bytes. Writing the go bit then starts exactly one flash cycle. The engine frames the cycle with chip select and shifts every byte out most significant bit first. It samples the input line on each rising clock edge and stores read bytes back into the data buffer. Status bits report whether a cycle is running, has finished, or was refused.

When the prefix register is non-zero, the prefix byte goes out in its own chip-select frame just before the main frame, and nothing can intervene between the two. A typical use is a write-enable ahead of a program or erase. Once the lock bit is set, the menu, the type table and the prefix can no longer change, so only the commands already on the menu can run.

The register port is plain and has no stream handshake. Every write completes in the cycle it is presented, and reads are combinational, so no back-pressure exists at the block's edge. Register word offsets: 0 control, 1 status, 2 address, 3 prefix, 4 type table, 5 menu entries 0 to 3, 6 menu entries 4 to 7. Words 16 to 31 are the data buffer. Buffer byte j sits in word 16 + j/4, lane j%4, with lane 0 at bits 7:0.

Top module: `sfc_engine`

## Requirements
- R1: After reset, the control, address, prefix, type and menu words read zero, the status word reads zero, chip select is high and SCLK is low.
- R2: Writing control with bit 0 (go) set starts one cycle using menu entry bits 6:4. The first byte of the main frame is that entry's opcode. At the end of the frame, chip select rises, busy (status bit 0) clears and done (status bit 1) sets.
- R3: The cycle type of entry i is type-table bits 2i+1:2i, coded as 0 read, 1 write, 2 read with address, 3 write with address. Both address types send address bits 23:16, then 15:8, then 7:0 after the opcode. Address register bits 31:24 are dropped and read back as zero.
- R4: With control bit 15 set, a cycle moves (control bits 14:8) + 1 data bytes. Write types send buffer bytes from index 0 upward, each most significant bit first.
- R5: Read types send zero bytes in the data phase and store the received bytes into the buffer from index 0 upward. Buffer bytes beyond the count keep their old value.
- R6: A non-zero prefix register sends that one byte in a separate chip-select frame directly before the main frame. A zero prefix sends no extra frame.
- R7: While busy, a go and any write to the control, address, prefix, type, menu or buffer words are ignored.
- R8: Writing 1 to status bit 1 or bit 2 clears done or error, and writing 0 leaves them set. Starting a new cycle does not clear them.
- R9: A go with bit 15 clear and a non-zero count field, or with bit 15 set and count field + 1 above 64, sets error (status bit 2) and sends nothing.
- R10: Writing 1 to status bit 3 sets the lock, which holds until reset. While locked, writes to the menu, type and prefix words are ignored, and cycles still run from the existing menu.
- R11: Control bit 16 set makes each SCLK high phase HALF_FAST clocks; clear makes it HALF_SLOW clocks.
- R12: SCLK stays low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The main cycle is swept over all four cycle types, data lengths of zero, one, three and the full 64 bytes, prefix on and off, and both clock classes. Zero-length cycles separate command-only framing from data framing. The three-byte case exposes ordering faults in the buffer and the address. The full length exercises the buffer edge and the count field. A flash model answers with a byte that depends on its position in the frame, so a stored read byte that is shifted or misaligned shows up as a wrong value. Separate runs cover writes during busy, the write-one-to-clear rules, refused gos and the lock.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PFX, S_GAP, S_OP, S_ADR, S_DAT
  } seq_e;

  localparam int REG_CTRL  = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_ADDR  = 2;
  localparam int REG_PFX   = 3;
  localparam int REG_TYPES = 4;
  localparam int REG_MLO   = 5;
  localparam int REG_MHI   = 6;
  localparam int MENU_N    = 8;
endpackage

// File: rtl/sfc_clkdiv.sv
`timescale 1ns/1ps
module sfc_clkdiv #(
  parameter int HALF_SLOW = 3,
  parameter int HALF_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfc_shifter.sv
`timescale 1ns/1ps
module sfc_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx
);
  logic [7:0] sh_q;
  logic [7:0] rx_q;
  logic [2:0] bit_q;
  logic       act_q;
  logic       sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rx_q <= '0; bit_q <= '0;
      act_q <= 1'b0; sclk_q <= 1'b0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        sh_q <= tx; bit_q <= '0; act_q <= 1'b1; sclk_q <= 1'b0;
      end else if (act_q && tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            act_q     <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = sh_q[7];
  assign rx   = rx_q;
endmodule

// File: rtl/sfc_engine.sv
`timescale 1ns/1ps
module sfc_engine #(
  parameter int BUF_BYTES = 64,
  parameter int HALF_SLOW = 3,
  parameter int HALF_FAST = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [$clog2(BUF_BYTES/4):0]           reg_addr,
  input  logic                                   reg_wr,
  input  logic [3:0]                             reg_be,
  input  logic [31:0]                            reg_wdata,
  output logic [31:0]                            reg_rdata,
  output logic                                   spi_sclk,
  output logic                                   spi_cs_n,
  output logic                                   spi_mosi,
  input  logic                                   spi_miso
);
  import sfc_pkg::*;

  localparam int WORDS  = BUF_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int RA_W   = WSEL_W + 1;
  localparam int BI_W   = $clog2(BUF_BYTES);

  logic [23:0] ctrl_q, ctrl_new;
  logic [23:0] addr_q;
  logic [7:0]  prefix_q;
  logic [15:0] types_q;
  logic [7:0]  menu_q [MENU_N];
  logic [7:0]  buf_q  [BUF_BYTES];
  logic        busy_q, done_q, err_q, lock_q;

  logic              is_data;
  logic [WSEL_W-1:0] word;
  logic              cfg_wr, sts_wr, ctl_hit, addr_hit;
  logic              go_req, bad_go;
  logic [1:0]        typ;
  logic [7:0]        n_data;

  assign is_data  = reg_addr[RA_W-1];
  assign word     = reg_addr[WSEL_W-1:0];
  assign cfg_wr   = reg_wr && !is_data;
  assign sts_wr   = cfg_wr && word == WSEL_W'(REG_STAT) && reg_be[0];
  assign ctl_hit  = cfg_wr && word == WSEL_W'(REG_CTRL);
  assign addr_hit = cfg_wr && word == WSEL_W'(REG_ADDR);

  always_comb begin
    ctrl_new = ctrl_q;
    for (int k = 0; k < 3; k++)
      if (reg_be[k]) ctrl_new[8*k +: 8] = reg_wdata[8*k +: 8];
    ctrl_new[0] = 1'b0;
  end

  assign go_req = ctl_hit && !busy_q && reg_be[0] && reg_wdata[0];
  assign bad_go = ctrl_new[15] ? ({1'b0, ctrl_new[14:8]} >= 8'(BUF_BYTES))
                               : (ctrl_new[14:8] != 7'd0);
  assign typ    = types_q[2*ctrl_q[6:4] +: 2];
  assign n_data = ctrl_q[15] ? ({1'b0, ctrl_q[14:8]} + 8'd1) : 8'd0;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; addr_q <= '0; prefix_q <= '0; types_q <= '0; lock_q <= 1'b0;
      for (int i = 0; i < MENU_N; i++) menu_q[i] <= '0;
    end else begin
      if (sts_wr && reg_wdata[3]) lock_q <= 1'b1;
      if (cfg_wr && !busy_q) begin
        if (word == WSEL_W'(REG_CTRL)) ctrl_q <= ctrl_new;
        if (word == WSEL_W'(REG_ADDR))
          for (int k = 0; k < 3; k++)
            if (reg_be[k]) addr_q[8*k +: 8] <= reg_wdata[8*k +: 8];
        if (!lock_q) begin
          if (word == WSEL_W'(REG_PFX) && reg_be[0]) prefix_q <= reg_wdata[7:0];
          if (word == WSEL_W'(REG_TYPES))
            for (int k = 0; k < 2; k++)
              if (reg_be[k]) types_q[8*k +: 8] <= reg_wdata[8*k +: 8];
          for (int k = 0; k < 4; k++) begin
            if (word == WSEL_W'(REG_MLO) && reg_be[k]) menu_q[k]   <= reg_wdata[8*k +: 8];
            if (word == WSEL_W'(REG_MHI) && reg_be[k]) menu_q[k+4] <= reg_wdata[8*k +: 8];
          end
        end
      end
    end
  end

  // serial path
  logic       tick, ld_q, bdone;
  logic [7:0] tx_q, brx;
  logic       cs_q;
  seq_e       st_q;
  logic [7:0] bcnt_q;
  logic [BI_W-1:0] cur_i, nxt_i;

  assign cur_i = bcnt_q[BI_W-1:0];
  assign nxt_i = cur_i + 1'b1;

  sfc_clkdiv #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .fast(ctrl_q[16]), .tick(tick)
  );

  sfc_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(ld_q), .tx(tx_q),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .byte_done(bdone), .rx(brx)
  );

  // data buffer: port side when idle, engine side during read data
  always_ff @(posedge clk) begin
    if (reg_wr && is_data && !busy_q)
      for (int k = 0; k < 4; k++)
        if (reg_be[k]) buf_q[{word, 2'(k)}] <= reg_wdata[8*k +: 8];
    if (st_q == S_DAT && bdone && !typ[0]) buf_q[cur_i] <= brx;
  end

  // cycle sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      cs_q <= 1'b1; ld_q <= 1'b0; tx_q <= '0; bcnt_q <= '0;
    end else begin
      ld_q <= 1'b0;
      if (sts_wr && reg_wdata[1]) done_q <= 1'b0;
      if (sts_wr && reg_wdata[2]) err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (go_req) begin
          if (bad_go) err_q <= 1'b1;
          else begin
            busy_q <= 1'b1; cs_q <= 1'b0; ld_q <= 1'b1;
            if (prefix_q != 8'd0) begin tx_q <= prefix_q; st_q <= S_PFX; end
            else begin tx_q <= menu_q[ctrl_new[6:4]]; st_q <= S_OP; end
          end
        end
        S_PFX: if (bdone) begin cs_q <= 1'b1; st_q <= S_GAP; end
        S_GAP: if (tick) begin
          cs_q <= 1'b0; ld_q <= 1'b1; tx_q <= menu_q[ctrl_q[6:4]]; st_q <= S_OP;
        end
        S_OP, S_ADR: if (bdone) begin
          if (st_q == S_OP && typ[1]) begin
            bcnt_q <= '0; ld_q <= 1'b1; tx_q <= addr_q[23:16]; st_q <= S_ADR;
          end else if (st_q == S_ADR && bcnt_q != 8'd2) begin
            bcnt_q <= bcnt_q + 8'd1; ld_q <= 1'b1;
            tx_q   <= (bcnt_q == 8'd0) ? addr_q[15:8] : addr_q[7:0];
          end else if (n_data != 8'd0) begin
            bcnt_q <= '0; ld_q <= 1'b1; st_q <= S_DAT;
            tx_q   <= typ[0] ? buf_q[0] : 8'h00;
          end else begin
            cs_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b1; st_q <= S_IDLE;
          end
        end
        S_DAT: if (bdone) begin
          if (bcnt_q + 8'd1 == n_data) begin
            cs_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            bcnt_q <= bcnt_q + 8'd1; ld_q <= 1'b1;
            tx_q   <= typ[0] ? buf_q[nxt_i] : 8'h00;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign spi_cs_n = cs_q;

  always_comb begin
    reg_rdata = '0;
    if (is_data) begin
      for (int k = 0; k < 4; k++) reg_rdata[8*k +: 8] = buf_q[{word, 2'(k)}];
    end else begin
      case (word)
        WSEL_W'(REG_CTRL):  reg_rdata = {8'd0, ctrl_q};
        WSEL_W'(REG_STAT):  reg_rdata = {28'd0, lock_q, err_q, done_q, busy_q};
        WSEL_W'(REG_ADDR):  reg_rdata = {8'd0, addr_q};
        WSEL_W'(REG_PFX):   reg_rdata = {24'd0, prefix_q};
        WSEL_W'(REG_TYPES): reg_rdata = {16'd0, types_q};
        WSEL_W'(REG_MLO):   reg_rdata = {menu_q[3], menu_q[2], menu_q[1], menu_q[0]};
        WSEL_W'(REG_MHI):   reg_rdata = {menu_q[7], menu_q[6], menu_q[5], menu_q[4]};
        default:            reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfc_engine_chk.sv
`timescale 1ns/1ps
module sfc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sclk,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        lock,
  input logic        addr_hit,
  input logic [23:0] addr_q,
  input logic [7:0]  prefix_q,
  input logic [15:0] types_q
);
  // R12
  sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R1
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $fell(busy));
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> (!busy && cs_n));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && addr_hit) |=> $stable(addr_q));
  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (lock && $stable(prefix_q) && $stable(types_q)));
endmodule

bind sfc_engine sfc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .busy(busy_q), .done(done_q), .err(err_q), .lock(lock_q),
  .addr_hit(addr_hit), .addr_q(addr_q), .prefix_q(prefix_q), .types_q(types_q)
);

// File: tb/sfc_engine_bench.sv
`timescale 1ns/1ps
module sfc_engine_bench;
  localparam int BUF_BYTES = 64;
  localparam int HS = 3;
  localparam int HF = 2;
  localparam int RA_W = 5;
  localparam int A_CTRL = 0, A_STAT = 1, A_ADDR = 2, A_PFX = 3, A_TYP = 4, A_MLO = 5, A_MHI = 6, A_DAT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [RA_W-1:0] reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [3:0]      reg_be = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  sfc_engine #(.BUF_BYTES(BUF_BYTES), .HALF_SLOW(HS), .HALF_FAST(HF)) u_sfc_engine (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 37 + 11);
  endfunction

  function automatic logic [7:0] wpat(input int s, input int j);
    return 8'(j * 13 + s * 5 + 7);
  endfunction

  // flash model: logs frames, answers resp(byte position in frame)
  logic [7:0] cur [128];
  logic [7:0] last [128];
  logic [7:0] prev [128];
  int cur_len = 0, last_len = 0, prev_len = 0, nframes = 0, bitn = 0, hi_len = 0;
  logic [7:0] sh_in = '0;
  realtime hi_t = 0;

  always @(negedge spi_cs_n) begin
    logic [7:0] r;
    cur_len = 0; bitn = 0; r = resp(0); spi_miso = r[7];
  end
  always @(posedge spi_cs_n) begin
    if (nframes >= 0 && $time > 0) begin
      for (int i = 0; i < 128; i++) begin prev[i] = last[i]; last[i] = cur[i]; end
      prev_len = last_len; last_len = cur_len; nframes++;
    end
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh_in = {sh_in[6:0], spi_mosi};
    bitn++;
    if (bitn == 8) begin cur[cur_len] = sh_in; cur_len++; bitn = 0; end
    hi_t = $realtime;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] r;
    hi_len = int'(($realtime - hi_t) / 8.0);
    r = resp(cur_len); spi_miso = r[7 - bitn];
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_addr = RA_W'(a); reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = RA_W'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, v);
      if (v[0] == 1'b0) return;
    end
    check("R2 busy never cleared", 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] ctrl(input int idx, input int n, input logic fast);
    logic den;
    logic [6:0] cm1;
    den = (n > 0);
    cm1 = (n > 0) ? 7'(n - 1) : 7'd0;
    return {15'd0, fast, den, cm1, 1'b0, 3'(idx), 3'b000, 1'b1};
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R2 watchdog expired actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] av;
    int s;
    int f0;
    s = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", 32'(spi_cs_n), 32'd1);
    check("R1 sclk", 32'(spi_sclk), 32'd0);
    rd(A_STAT, v); check("R1 status", v, 32'd0);
    rst_n = 1'b1;
    rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    rd(A_ADDR, v); check("R1 addr", v, 32'd0);
    rd(A_MLO, v);  check("R1 menu", v, 32'd0);

    wr(A_MLO, 32'h36251403, 4'hF);
    wr(A_MHI, 32'h7A695847, 4'hF);
    wr(A_TYP, 32'h0000E4E4, 4'hF);
    wr(A_ADDR, 32'hC3123456, 4'hF);
    rd(A_ADDR, v); check("R3 upper address bits read zero", v, 32'h00123456);

    // sweep: prefix x type x length, clock class alternating
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 4; t++)
        for (int li = 0; li < 4; li++) begin
          int n, idx, hdr;
          logic fast;
          n = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 64;
          s++;
          idx = t + 4 * (s % 2);
          fast = 1'(li ^ p);
          hdr = 1 + ((t >= 2) ? 3 : 0);
          av = {8'hA5, 8'(s * 7), 8'(s * 3 + 1), 8'(s)};
          wr(A_PFX, p ? 32'h06 : 32'h0, 4'h1);
          wr(A_ADDR, av, 4'hF);
          for (int w = 0; w < 16; w++)
            if (t[0]) wr(A_DAT + w, {wpat(s, 4*w+3), wpat(s, 4*w+2), wpat(s, 4*w+1), wpat(s, 4*w)}, 4'hF);
            else      wr(A_DAT + w, 32'hEEEEEEEE, 4'hF);
          wr(A_STAT, 32'h6, 4'h1);
          f0 = nframes;
          wr(A_CTRL, ctrl(idx, n, fast), 4'h7);
          wait_idle();
          rd(A_STAT, v); check("R2 done after cycle", v[1:0], 2'b10);
          check("R6 frame count", nframes - f0, p ? 2 : 1);
          if (p != 0) begin
            check("R6 prefix frame length", prev_len, 1);
            check("R6 prefix byte", prev[0], 8'h06);
          end
          check("R4 main frame length", last_len, hdr + n);
          check("R2 opcode", last[0], 8'(8'h03 + 8'h11 * idx));
          if (t >= 2) begin
            check("R3 address hi", last[1], av[23:16]);
            check("R3 address mid", last[2], av[15:8]);
            check("R3 address lo", last[3], av[7:0]);
          end
          if (t[0]) begin
            for (int j = 0; j < n; j++) check("R4 write byte", last[hdr + j], wpat(s, j));
          end else begin
            for (int j = 0; j < n; j++) check("R5 read phase sends zero", last[hdr + j], 8'h00);
            for (int w = 0; w < 16; w++) begin
              rd(A_DAT + w, v);
              for (int k = 0; k < 4; k++) begin
                int j;
                j = 4 * w + k;
                check("R5 read buffer byte", v[8*k +: 8], (j < n) ? resp(hdr + j) : 8'hEE);
              end
            end
          end
          if (hdr + n > 0) check("R11 sclk high time", hi_len, fast ? HF : HS);
        end

    // R7 writes and go while busy; R8 done survives a new go
    wr(A_PFX, 32'h0, 4'h1);
    wr(A_ADDR, 32'h00ABCDEF, 4'hF);
    f0 = nframes;
    wr(A_CTRL, ctrl(3, 64, 1'b0), 4'h7);
    rd(A_STAT, v);
    check("R7 busy during cycle", v[0], 1'b1);
    check("R8 done kept by new go", v[1], 1'b1);
    wr(A_ADDR, 32'h00111111, 4'hF);
    wr(A_CTRL, ctrl(0, 1, 1'b1), 4'h7);
    wait_idle();
    rd(A_ADDR, v); check("R7 address write ignored while busy", v, 32'h00ABCDEF);
    rd(A_CTRL, v); check("R7 control write ignored while busy", v[16:4], ctrl(3, 64, 1'b0) >> 4);
    repeat (200) @(negedge clk);
    check("R7 go ignored while busy", nframes - f0, 1);
    check("R7 line idle after", 32'(spi_cs_n), 32'd1);

    // R8 / R9 status rules
    wr(A_STAT, 32'h2, 4'h1);
    rd(A_STAT, v); check("R8 done cleared by one", v[2:0], 3'b000);
    f0 = nframes;
    wr(A_CTRL, 32'h0000_0301, 4'h7);
    rd(A_STAT, v); check("R9 count without data flag", v[2:0], 3'b100);
    wr(A_STAT, 32'h0, 4'h1);
    rd(A_STAT, v); check("R8 zero write keeps error", v[2], 1'b1);
    wr(A_STAT, 32'h4, 4'h1);
    rd(A_STAT, v); check("R8 error cleared by one", v[2], 1'b0);
    wr(A_CTRL, 32'h0000_C001, 4'h7);
    rd(A_STAT, v); check("R9 count above buffer", v[2:0], 3'b100);
    repeat (50) @(negedge clk);
    check("R9 nothing sent", nframes - f0, 0);
    wr(A_STAT, 32'h4, 4'h1);

    // R10 lock
    wr(A_STAT, 32'h8, 4'h1);
    wr(A_MLO, 32'h0, 4'hF);
    wr(A_TYP, 32'h0, 4'hF);
    wr(A_PFX, 32'h55, 4'h1);
    wr(A_STAT, 32'h0, 4'h1);
    rd(A_STAT, v); check("R10 lock held", v[3], 1'b1);
    rd(A_MLO, v);  check("R10 menu locked", v, 32'h36251403);
    rd(A_TYP, v);  check("R10 types locked", v, 32'h0000E4E4);
    rd(A_PFX, v);  check("R10 prefix locked", v, 32'h0);
    f0 = nframes;
    wr(A_CTRL, ctrl(1, 0, 1'b1), 4'h7);
    wait_idle();
    check("R10 locked menu usable", nframes - f0, 1);
    check("R10 locked opcode", last[0], 8'h14);
    check("R10 locked frame length", last_len, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule